// File: doc/BRIEF.md
# Secure Region Address Filter

This block sits between a requesting master and a downstream slave and decides, per request, whether the access may proceed. Every request carries a single address, a read/write flag, a secure/non-secure flag and a master ID. The filter looks the address up in a set of programmable protection regions. The highest-numbered enabled region that covers the address supplies four permission bits: secure read, secure write, non-secure read and non-secure write. Region 0 always covers the whole address space and acts as the background region.

Allowed requests are forwarded unchanged one cycle after acceptance. Denied requests are never forwarded. Instead they produce a one-cycle deny pulse, which can optionally be marked as an error, and the failing access is logged into capture registers. An interrupt can also be raised. All configuration goes through a zero-wait APB-style register port. A lockdown range freezes a chosen span of regions so that their registers become read-only.

The request path is a small state machine. In `ST_IDLE` it accepts a request. The transition *accept-allowed* leads to `ST_PASS` and *accept-denied* leads to `ST_BLOCK`. `ST_PASS` holds the forwarded request until the slave takes it (*downstream-take*, back to `ST_IDLE`). `ST_BLOCK` lasts one cycle, emits the deny pulse and the capture event, and then returns to idle (*deny-done*).

Top module: `secfilt_top`

## Requirements
- R1: After reset, `req_ready`=1, `fwd_valid`=0, `deny_valid`=0 and `irq`=0. The status register (0x010), the lockdown enable (0x00C) and every attribute register of regions 1 and up read 0.
- R2: Offset 0x000 is read-only and returns the address width in bits [7:0] and the region count in bits [15:8] (0x1020 with defaults).
- R3: Region n has its base-low register at 0x100+n*0x10, its base-high register at +0x4 and its attribute register at +0x8. The attribute register holds enable in bit 0, size in bits [13:8] and permissions in bits [31:28] as {ns_wr, ns_rd, s_wr, s_rd}. When enabled regions overlap, the highest-numbered region decides. An address that no region 1..N-1 covers uses region 0.
- R4: A request whose selected permission bit is set appears on the `fwd_*` outputs one cycle after acceptance, with address, type and ID unchanged. It stays there, stable, until `fwd_ready` is high.
- R5: A denied request is never forwarded. One cycle after acceptance `deny_valid` pulses for exactly one cycle with `deny_id`. `deny_err` equals bit 1 of the action register (0x004).
- R6: On a denial with no failure pending, the address is logged to 0x020 (low 32 bits) and 0x024 (high bits), the type to 0x028 (bit 0 write, bit 1 non-secure) and the ID to 0x02C. While a failure is pending, later denials leave these values unchanged.
- R7: Status bit 0 at 0x010 is set by a logged failure. Any write to 0x014 clears it. `irq` equals the status bit ANDed with action bit 0.
- R8: Lockdown range 0x008 holds the first region in [3:0] and the last in [11:8]. Writing 1 to bit 0 of 0x00C enables lockdown until reset. While lockdown is enabled, writes to region registers inside the range, writes to 0x008 and attempts to clear 0x00C are all ignored.
- R9: The base registers of region 0 always read 0. Its attribute register reads enable=1 and size=63, and only its permission bits are writable. They reset to secure read and secure write allowed.
- R10: A region spans 2^(size+1) bytes. A size below 14 acts as 14. Base bits below the span are stored but ignored when matching.
- R11: `req_ready` is high only in the idle state, so at most one request is in flight.
- R12: If a denial is logged in the same cycle as a write to 0x014, the new failure is captured and the status stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| apb_sel | input | 1 | Register port select |
| apb_enable | input | 1 | Register port access phase |
| apb_write | input | 1 | 1 = write, 0 = read |
| apb_addr | input | 12 | Register byte offset |
| apb_wdata | input | 32 | Write data |
| apb_rdata | output | 32 | Read data |
| req_valid | input | 1 | Upstream request present |
| req_ready | output | 1 | Filter can accept a request |
| req_addr | input | AW | Request address |
| req_write | input | 1 | 1 = write access |
| req_nonsec | input | 1 | 1 = non-secure access |
| req_id | input | IDW | Master ID |
| fwd_valid | output | 1 | Allowed request presented downstream |
| fwd_ready | input | 1 | Downstream takes the request |
| fwd_addr | output | AW | Forwarded address |
| fwd_write | output | 1 | Forwarded write flag |
| fwd_nonsec | output | 1 | Forwarded security flag |
| fwd_id | output | IDW | Forwarded ID |
| deny_valid | output | 1 | One-cycle denial pulse |
| deny_err | output | 1 | Denial returns an error response |
| deny_id | output | IDW | ID of the denied request |
| irq | output | 1 | Failure interrupt |

## Verification
The capture logic has two inputs that can arrive together: a denial leaving `ST_BLOCK` and a register write to the clear offset. The bench first leaves a failure pending. It then starts a fresh denied request and an APB clear in the same cycle, so that the clear's access phase lands on the edge where the denial is logged. The run passes only if the log then holds the new address and ID and the status bit is still 1. Throughout the run, a behavioural model of the regions, lockdown and pending state predicts `irq` on every clock.

// File: rtl/secfilt_pkg.sv
`timescale 1ns/1ps
package secfilt_pkg;

    // Permission bits of one region, MSB first as laid out in the attribute word
    typedef struct packed {
        logic ns_wr;
        logic ns_rd;
        logic s_wr;
        logic s_rd;
    } perm_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PASS  = 2'd1,
        ST_BLOCK = 2'd2
    } fsm_t;

    localparam int          SZ_MIN    = 14;
    localparam int          SZ_FULL   = 63;
    localparam logic [3:0]  RGN0_PERM = 4'b0011;

endpackage

// File: rtl/secfilt_match.sv
`timescale 1ns/1ps
module secfilt_match
    import secfilt_pkg::*;
#(
    parameter int NREG = 16,
    parameter int AW   = 32
) (
    input  logic [AW-1:0]             addr,
    input  logic [NREG-1:0][AW-1:0]   base,
    input  logic [NREG-1:0][5:0]      size,
    input  logic [NREG-1:0]           en,
    input  perm_t [NREG-1:0]          perm,
    output perm_t                     sel_perm
);

    logic [NREG-1:0] hit;

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_rgn
            logic [5:0]    sz_eff;
            logic [AW-1:0] keep;
            assign sz_eff = (size[g] < 6'(SZ_MIN)) ? 6'(SZ_MIN) : size[g];
            for (genvar b = 0; b < AW; b++) begin : g_bit
                assign keep[b] = (7'(b) > {1'b0, sz_eff});
            end
            assign hit[g] = en[g] && (((addr ^ base[g]) & keep) == '0);
        end
    endgenerate

    // Highest-numbered hit wins; region 0 always hits
    always_comb begin
        sel_perm = perm[0];
        for (int i = 0; i < NREG; i++) begin
            if (hit[i]) sel_perm = perm[i];
        end
    end

endmodule

// File: rtl/secfilt_regs.sv
`timescale 1ns/1ps
module secfilt_regs
    import secfilt_pkg::*;
#(
    parameter int NREG = 16,
    parameter int AW   = 32,
    parameter int IDW  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    psel,
    input  logic                    penable,
    input  logic                    pwrite,
    input  logic [11:0]             paddr,
    input  logic [31:0]             pwdata,
    output logic [31:0]             prdata,
    input  logic                    fail_evt,
    input  logic [AW-1:0]           fail_addr,
    input  logic                    fail_write,
    input  logic                    fail_ns,
    input  logic [IDW-1:0]          fail_id,
    output logic [NREG-1:0][AW-1:0] base,
    output logic [NREG-1:0][5:0]    size,
    output logic [NREG-1:0]         en,
    output perm_t [NREG-1:0]        perm,
    output logic [1:0]              action,
    output logic                    pending
);

    logic [NREG-1:0][AW-1:0] base_q;
    logic [NREG-1:0][5:0]    size_q;
    logic [NREG-1:0]         en_q;
    perm_t [NREG-1:0]        perm_q;
    logic [1:0]              action_q;
    logic [3:0]              lock_lo_q;
    logic [3:0]              lock_hi_q;
    logic                    lock_en_q;
    logic                    pending_q;
    logic [AW-1:0]           f_addr_q;
    logic                    f_wr_q;
    logic                    f_ns_q;
    logic [IDW-1:0]          f_id_q;

    logic                    wr_en;
    logic                    rgn_sel;
    logic                    clr_wr;
    logic [3:0]              ridx;
    logic [1:0]              rsub;
    logic [NREG-1:0]         locked;
    logic [63:0]             base_ext;
    logic [63:0]             fa_ext;

    assign wr_en    = psel && penable && pwrite;
    assign ridx     = paddr[7:4];
    assign rsub     = paddr[3:2];
    assign rgn_sel  = (paddr[11:8] == 4'h1) && (paddr[1:0] == 2'b00)
                      && ({28'b0, ridx} < 32'(NREG));
    assign clr_wr   = wr_en && (paddr == 12'h014);
    assign base_ext = 64'(base_q[ridx]);
    assign fa_ext   = 64'(f_addr_q);

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_lock
            assign locked[g] = lock_en_q && (4'(g) >= lock_lo_q) && (4'(g) <= lock_hi_q);
        end
    endgenerate

    // Region registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                base_q[i] <= '0;
                size_q[i] <= (i == 0) ? 6'(SZ_FULL) : 6'd0;
                en_q[i]   <= (i == 0);
                perm_q[i] <= (i == 0) ? perm_t'(RGN0_PERM) : perm_t'(4'b0000);
            end
        end else if (wr_en && rgn_sel && !locked[ridx]) begin
            case (rsub)
                2'd0: if (ridx != 4'd0) base_q[ridx] <= AW'({base_ext[63:32], pwdata});
                2'd1: if (ridx != 4'd0) base_q[ridx] <= AW'({pwdata, base_ext[31:0]});
                2'd2: begin
                    perm_q[ridx] <= perm_t'(pwdata[31:28]);
                    if (ridx != 4'd0) begin
                        en_q[ridx]   <= pwdata[0];
                        size_q[ridx] <= pwdata[13:8];
                    end
                end
                default: ;
            endcase
        end
    end

    // Control, lockdown and failure log
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            action_q  <= '0;
            lock_lo_q <= '0;
            lock_hi_q <= '0;
            lock_en_q <= 1'b0;
            pending_q <= 1'b0;
            f_addr_q  <= '0;
            f_wr_q    <= 1'b0;
            f_ns_q    <= 1'b0;
            f_id_q    <= '0;
        end else begin
            if (wr_en && paddr == 12'h004) action_q <= pwdata[1:0];
            if (wr_en && paddr == 12'h008 && !lock_en_q) begin
                lock_lo_q <= pwdata[3:0];
                lock_hi_q <= pwdata[11:8];
            end
            if (wr_en && paddr == 12'h00C && pwdata[0]) lock_en_q <= 1'b1;
            if (fail_evt && (!pending_q || clr_wr)) begin
                pending_q <= 1'b1;
                f_addr_q  <= fail_addr;
                f_wr_q    <= fail_write;
                f_ns_q    <= fail_ns;
                f_id_q    <= fail_id;
            end else if (clr_wr) begin
                pending_q <= 1'b0;
            end
        end
    end

    always_comb begin
        prdata = '0;
        if (rgn_sel) begin
            case (rsub)
                2'd0:    prdata = base_ext[31:0];
                2'd1:    prdata = base_ext[63:32];
                2'd2:    prdata = {perm_q[ridx], 14'b0, size_q[ridx], 7'b0, en_q[ridx]};
                default: prdata = '0;
            endcase
        end else begin
            case (paddr)
                12'h000: prdata = (32'(NREG) << 8) | 32'(AW);
                12'h004: prdata = {30'b0, action_q};
                12'h008: prdata = {20'b0, lock_hi_q, 4'b0, lock_lo_q};
                12'h00C: prdata = {31'b0, lock_en_q};
                12'h010: prdata = {31'b0, pending_q};
                12'h020: prdata = fa_ext[31:0];
                12'h024: prdata = fa_ext[63:32];
                12'h028: prdata = {30'b0, f_ns_q, f_wr_q};
                12'h02C: prdata = 32'(f_id_q);
                default: prdata = '0;
            endcase
        end
    end

    assign base    = base_q;
    assign size    = size_q;
    assign en      = en_q;
    assign perm    = perm_q;
    assign action  = action_q;
    assign pending = pending_q;

    AST_LOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_q && !clr_wr) |=> $stable(f_addr_q) && $stable(f_id_q)); // R6

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lock_en_q |=> lock_en_q); // R8

    AST_CLEAR_WINS_NOT: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_evt && clr_wr) |=> pending_q); // R12

endmodule

// File: rtl/secfilt_pipe.sv
`timescale 1ns/1ps
module secfilt_pipe
    import secfilt_pkg::*;
#(
    parameter int AW  = 32,
    parameter int IDW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic [AW-1:0]  req_addr,
    input  logic           req_write,
    input  logic           req_ns,
    input  logic [IDW-1:0] req_id,
    input  perm_t          sel_perm,
    input  logic           err_en,
    output logic           fwd_valid,
    input  logic           fwd_ready,
    output logic [AW-1:0]  fwd_addr,
    output logic           fwd_write,
    output logic           fwd_ns,
    output logic [IDW-1:0] fwd_id,
    output logic           deny_valid,
    output logic           deny_err,
    output logic           fail_evt
);

    fsm_t           state_q;
    fsm_t           state_d;
    logic           allow;
    logic [AW-1:0]  addr_q;
    logic           wr_q;
    logic           ns_q;
    logic [IDW-1:0] id_q;

    always_comb begin
        unique case ({req_ns, req_write})
            2'b00: allow = sel_perm.s_rd;
            2'b01: allow = sel_perm.s_wr;
            2'b10: allow = sel_perm.ns_rd;
            2'b11: allow = sel_perm.ns_wr;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = allow ? ST_PASS : ST_BLOCK;
            ST_PASS:  if (fwd_ready) state_d = ST_IDLE;
            ST_BLOCK: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wr_q    <= 1'b0;
            ns_q    <= 1'b0;
            id_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                addr_q <= req_addr;
                wr_q   <= req_write;
                ns_q   <= req_ns;
                id_q   <= req_id;
            end
        end
    end

    always_comb begin
        req_ready  = 1'b0;
        fwd_valid  = 1'b0;
        deny_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready  = 1'b1;
            ST_PASS:  fwd_valid  = 1'b1;
            ST_BLOCK: deny_valid = 1'b1;
            default:  ;
        endcase
        deny_err = deny_valid && err_en;
        fail_evt = deny_valid;
    end

    assign fwd_addr  = addr_q;
    assign fwd_write = wr_q;
    assign fwd_ns    = ns_q;
    assign fwd_id    = id_q;

    AST_FWD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable(fwd_addr) && $stable(fwd_id))); // R4

    AST_DENY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        deny_valid |=> !deny_valid); // R5

    AST_NO_DUAL: assert property (@(posedge clk) disable iff (!rst_n)
        !(fwd_valid && deny_valid)); // R5

    AST_ONE_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R11

endmodule

// File: rtl/secfilt_top.sv
`timescale 1ns/1ps
module secfilt_top
    import secfilt_pkg::*;
#(
    parameter int NREG = 16,
    parameter int AW   = 32,
    parameter int IDW  = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           apb_sel,
    input  logic           apb_enable,
    input  logic           apb_write,
    input  logic [11:0]    apb_addr,
    input  logic [31:0]    apb_wdata,
    output logic [31:0]    apb_rdata,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic [AW-1:0]  req_addr,
    input  logic           req_write,
    input  logic           req_nonsec,
    input  logic [IDW-1:0] req_id,
    output logic           fwd_valid,
    input  logic           fwd_ready,
    output logic [AW-1:0]  fwd_addr,
    output logic           fwd_write,
    output logic           fwd_nonsec,
    output logic [IDW-1:0] fwd_id,
    output logic           deny_valid,
    output logic           deny_err,
    output logic [IDW-1:0] deny_id,
    output logic           irq
);

    logic [NREG-1:0][AW-1:0] base;
    logic [NREG-1:0][5:0]    size;
    logic [NREG-1:0]         en;
    perm_t [NREG-1:0]        perm;
    perm_t                   sel_perm;
    logic [1:0]              action;
    logic                    pending;
    logic                    fail_evt;

    secfilt_regs #(.NREG(NREG), .AW(AW), .IDW(IDW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .psel       (apb_sel),
        .penable    (apb_enable),
        .pwrite     (apb_write),
        .paddr      (apb_addr),
        .pwdata     (apb_wdata),
        .prdata     (apb_rdata),
        .fail_evt   (fail_evt),
        .fail_addr  (fwd_addr),
        .fail_write (fwd_write),
        .fail_ns    (fwd_nonsec),
        .fail_id    (fwd_id),
        .base       (base),
        .size       (size),
        .en         (en),
        .perm       (perm),
        .action     (action),
        .pending    (pending)
    );

    secfilt_match #(.NREG(NREG), .AW(AW)) u_match (
        .addr     (req_addr),
        .base     (base),
        .size     (size),
        .en       (en),
        .perm     (perm),
        .sel_perm (sel_perm)
    );

    secfilt_pipe #(.AW(AW), .IDW(IDW)) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .req_write  (req_write),
        .req_ns     (req_nonsec),
        .req_id     (req_id),
        .sel_perm   (sel_perm),
        .err_en     (action[1]),
        .fwd_valid  (fwd_valid),
        .fwd_ready  (fwd_ready),
        .fwd_addr   (fwd_addr),
        .fwd_write  (fwd_write),
        .fwd_ns     (fwd_nonsec),
        .fwd_id     (fwd_id),
        .deny_valid (deny_valid),
        .deny_err   (deny_err),
        .fail_evt   (fail_evt)
    );

    assign deny_id = fwd_id;
    assign irq     = pending && action[0];

    AST_IRQ_NEEDS_LOG: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_evt && action[0]) |=> irq); // R7

endmodule

// File: tb/secfilt_top_bench.sv
`timescale 1ns/1ps
module secfilt_top_bench;

    localparam int AW  = 32;
    localparam int IDW = 4;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           apb_sel, apb_enable, apb_write;
    logic [11:0]    apb_addr;
    logic [31:0]    apb_wdata, apb_rdata;
    logic           req_valid, req_ready, req_write, req_nonsec;
    logic [AW-1:0]  req_addr;
    logic [IDW-1:0] req_id;
    logic           fwd_valid, fwd_ready, fwd_write, fwd_nonsec;
    logic [AW-1:0]  fwd_addr;
    logic [IDW-1:0] fwd_id;
    logic           deny_valid, deny_err;
    logic [IDW-1:0] deny_id;
    logic           irq;

    always #10 clk = ~clk;

    secfilt_top u_secfilt_top (
        .clk(clk), .rst_n(rst_n),
        .apb_sel(apb_sel), .apb_enable(apb_enable), .apb_write(apb_write),
        .apb_addr(apb_addr), .apb_wdata(apb_wdata), .apb_rdata(apb_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_nonsec(req_nonsec), .req_id(req_id),
        .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_addr(fwd_addr),
        .fwd_write(fwd_write), .fwd_nonsec(fwd_nonsec), .fwd_id(fwd_id),
        .deny_valid(deny_valid), .deny_err(deny_err), .deny_id(deny_id),
        .irq(irq)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // Behavioural reference model
    logic [31:0] m_base [16];
    int          m_size [16];
    bit          m_en   [16];
    logic [3:0]  m_perm [16];
    logic [1:0]  m_action;
    int          m_lf, m_ll;
    bit          m_lock;
    bit          exp_pend;
    logic [31:0] m_fa;
    logic [1:0]  m_fc;
    logic [3:0]  m_fid;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
        check(act === exp, req, act, exp);
    endtask

    function automatic bit model_allow(input logic [31:0] a, input bit wr, input bit ns);
        logic [3:0] p;
        p = m_perm[0];
        for (int i = 1; i < 16; i++) begin
            if (m_en[i]) begin
                int span;
                bit hitv;
                span = ((m_size[i] < 14) ? 14 : m_size[i]) + 1;
                hitv = (span >= 32) ? 1'b1 : ((a >> span) == (m_base[i] >> span));
                if (hitv) p = m_perm[i];
            end
        end
        if (ns) return wr ? p[3] : p[2];
        return wr ? p[1] : p[0];
    endfunction

    task automatic model_write(input logic [11:0] a, input logic [31:0] d);
        if (a == 12'h004) m_action = d[1:0];
        else if (a == 12'h008) begin
            if (!m_lock) begin m_lf = int'(d[3:0]); m_ll = int'(d[11:8]); end
        end
        else if (a == 12'h00C) begin
            if (d[0]) m_lock = 1;
        end
        else if (a == 12'h014) exp_pend = 0;
        else if (a[11:8] == 4'h1 && a[1:0] == 2'b00) begin
            int idx;
            idx = int'(a[7:4]);
            if (!(m_lock && idx >= m_lf && idx <= m_ll)) begin
                if (a[3:2] == 2'd0 && idx != 0) m_base[idx] = d;
                if (a[3:2] == 2'd2) begin
                    m_perm[idx] = d[31:28];
                    if (idx != 0) begin m_en[idx] = d[0]; m_size[idx] = int'(d[13:8]); end
                end
            end
        end
    endtask

    task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
        apb_sel = 1; apb_write = 1; apb_addr = a; apb_wdata = d; apb_enable = 0;
        @(negedge clk);
        apb_enable = 1;
        model_write(a, d);
        @(negedge clk);
        apb_sel = 0; apb_enable = 0; apb_write = 0;
    endtask

    task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
        apb_sel = 1; apb_write = 0; apb_addr = a; apb_enable = 0;
        @(negedge clk);
        apb_enable = 1;
        #2 d = apb_rdata;
        @(negedge clk);
        apb_sel = 0; apb_enable = 0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        apb_rd(a, d);
        check_eq(req, 64'(d), 64'(exp));
    endtask

    task automatic send(input string req, input logic [31:0] a, input bit wr, input bit ns, input logic [3:0] id);
        bit ok;
        check_eq("R11", 64'(req_ready), 64'(1));
        ok = model_allow(a, wr, ns);
        req_valid = 1; req_addr = a; req_write = wr; req_nonsec = ns; req_id = id;
        @(negedge clk);
        req_valid = 0;
        check_eq(req, 64'(fwd_valid), 64'(ok));
        check_eq(req, 64'(deny_valid), 64'(!ok));
        if (ok) begin
            check_eq("R4", 64'({fwd_addr, fwd_write, fwd_nonsec, fwd_id}), 64'({a, wr, ns, id}));
        end else begin
            check_eq("R5", 64'({deny_err, deny_id}), 64'({m_action[1], id}));
            if (!exp_pend) begin
                exp_pend = 1; m_fa = a; m_fc = {ns, wr}; m_fid = id;
            end
        end
        @(negedge clk);
    endtask

    // Per-clock comparison of the interrupt against the model
    always @(posedge clk) begin
        #5;
        if (rst_n && !finished) begin
            check_eq("R7", 64'(irq), 64'(exp_pend & m_action[0]));
            check(!(fwd_valid && deny_valid), "R5", 64'({fwd_valid, deny_valid}), 64'(0));
        end
    end

    initial begin
        #(20 * 190000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_base[i] = '0; m_size[i] = 0; m_en[i] = 0; m_perm[i] = '0;
        end
        m_perm[0] = 4'b0011; m_en[0] = 1; m_size[0] = 63;
        m_action = '0; m_lf = 0; m_ll = 0; m_lock = 0; exp_pend = 0;
        m_fa = '0; m_fc = '0; m_fid = '0;
        rst_n = 0; apb_sel = 0; apb_enable = 0; apb_write = 0; apb_addr = '0; apb_wdata = '0;
        req_valid = 0; req_addr = '0; req_write = 0; req_nonsec = 0; req_id = '0; fwd_ready = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        check_eq("R1", 64'({req_ready, fwd_valid, deny_valid, irq}), 64'(4'b1000));
        rd_chk("R1", 12'h010, 32'h0);
        rd_chk("R1", 12'h00C, 32'h0);
        rd_chk("R1", 12'h118, 32'h0);

        // R2 configuration word
        rd_chk("R2", 12'h000, 32'h0000_1020);

        // R9 region 0 fixed fields
        rd_chk("R9", 12'h108, 32'h3000_3F01);
        apb_wr(12'h100, 32'hFFFF_0000);
        rd_chk("R9", 12'h100, 32'h0);
        apb_wr(12'h108, 32'h3000_0000);
        rd_chk("R9", 12'h108, 32'h3000_3F01);

        // R4 secure accesses pass through the background region
        send("R4", 32'h0000_1234, 0, 0, 4'd3);
        send("R4", 32'h0000_5678, 1, 0, 4'd4);

        // R5 R6 R7 denial with action cleared
        send("R5", 32'h0000_2000, 1, 1, 4'd5);
        rd_chk("R7", 12'h010, 32'h1);
        rd_chk("R6", 12'h020, 32'h0000_2000);
        rd_chk("R6", 12'h024, 32'h0);
        rd_chk("R6", 12'h028, 32'h3);
        rd_chk("R6", 12'h02C, 32'h5);
        apb_wr(12'h004, 32'h3);
        check_eq("R7", 64'(irq), 64'(1));

        // R6 later failure must not overwrite the log
        send("R5", 32'h0000_3000, 0, 1, 4'd7);
        rd_chk("R6", 12'h020, 32'h0000_2000);
        rd_chk("R6", 12'h02C, 32'h5);
        apb_wr(12'h014, 32'h0);
        check_eq("R7", 64'(irq), 64'(0));
        rd_chk("R7", 12'h010, 32'h0);

        // R3 overlapping regions, highest wins
        apb_wr(12'h110, 32'h0001_0000);
        apb_wr(12'h118, 32'h4000_0F01);
        apb_wr(12'h120, 32'h0001_8000);
        apb_wr(12'h128, 32'hC000_0E01);
        send("R3", 32'h0001_0004, 1, 1, 4'd1);
        apb_wr(12'h014, 32'h0);
        send("R3", 32'h0001_0004, 0, 1, 4'd1);
        send("R3", 32'h0001_8004, 1, 1, 4'd2);
        send("R3", 32'h0003_0000, 1, 1, 4'd2);
        apb_wr(12'h014, 32'h0);

        // R10 size clamp and ignored low base bits
        apb_wr(12'h130, 32'h0004_1234);
        apb_wr(12'h138, 32'h4000_0501);
        rd_chk("R10", 12'h130, 32'h0004_1234);
        send("R10", 32'h0004_7FFC, 0, 1, 4'd6);
        send("R10", 32'h0004_8000, 0, 1, 4'd6);
        apb_wr(12'h014, 32'h0);

        // R11 and R4: downstream stall
        fwd_ready = 0;
        req_valid = 1; req_addr = 32'h0000_0500; req_write = 0; req_nonsec = 0; req_id = 4'd8;
        @(negedge clk);
        req_valid = 0;
        check_eq("R11", 64'({fwd_valid, req_ready}), 64'(2'b10));
        @(negedge clk);
        check_eq("R4", 64'({fwd_valid, req_ready, fwd_addr}), 64'({2'b10, 32'h0000_0500}));
        @(negedge clk);
        check_eq("R4", 64'({fwd_valid, fwd_id}), 64'({1'b1, 4'd8}));
        fwd_ready = 1;
        @(negedge clk);
        check_eq("R11", 64'({fwd_valid, req_ready}), 64'(2'b01));

        // R12 failure logged in the same cycle as a clear
        send("R5", 32'h0000_6000, 1, 1, 4'd2);
        req_valid = 1; req_addr = 32'h0000_7000; req_write = 1; req_nonsec = 1; req_id = 4'd9;
        apb_sel = 1; apb_write = 1; apb_addr = 12'h014; apb_wdata = '0; apb_enable = 0;
        @(negedge clk);
        req_valid = 0; apb_enable = 1;
        exp_pend = 1; m_fa = 32'h0000_7000; m_fc = 2'b11; m_fid = 4'd9;
        check_eq("R12", 64'(deny_valid), 64'(1));
        @(negedge clk);
        apb_sel = 0; apb_enable = 0; apb_write = 0;
        rd_chk("R12", 12'h010, 32'h1);
        rd_chk("R12", 12'h020, m_fa);
        rd_chk("R12", 12'h02C, 32'(m_fid));
        apb_wr(12'h014, 32'h0);

        // R8 lockdown of regions 2..3
        apb_wr(12'h008, 32'h0000_0302);
        apb_wr(12'h00C, 32'h1);
        apb_wr(12'h128, 32'h0);
        rd_chk("R8", 12'h128, 32'hC000_0E01);
        apb_wr(12'h120, 32'h0);
        rd_chk("R8", 12'h120, 32'h0001_8000);
        apb_wr(12'h118, 32'h4000_0F00);
        rd_chk("R8", 12'h118, 32'h4000_0F00);
        apb_wr(12'h00C, 32'h0);
        rd_chk("R8", 12'h00C, 32'h1);
        apb_wr(12'h008, 32'h0000_0F00);
        rd_chk("R8", 12'h008, 32'h0000_0302);
        send("R8", 32'h0001_8004, 1, 1, 4'd4);

        repeat (2) @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule